// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A frame opens with a low start bit, carries five to eight data bits with the least significant bit first, may add one parity bit, and ends with one, one and a half, or two high stop bits. Between frames the line rests high.

A small mode register sets the framing. It is loaded through a write strobe and holds five fields: stop code, parity enable, parity sense, data length and clock ratio. The block is advanced by a bit-rate enable pulse, `tick_i`. In 16x mode one bit lasts sixteen pulses. In 1x mode one bit lasts one pulse. Characters enter through a valid/ready handshake. The mode is captured together with the character, so writing the mode register while a frame is on the line has no effect on that frame.

Stop code 0 selects synchronous operation, which this block does not provide. With that code the block accepts no characters and holds the line high. One and a half stop bits cannot be produced at the 1x ratio. In that case the block raises a flag and sends two stop bits instead.

Top module: `async_char_tx`

## Requirements
- R1: After reset `txd_o`=1, `busy_o`=0, `ready_o`=1 and `illegal_o`=0. The mode register resets to stop code 1 (one stop bit), parity off, 8 data bits and 16x ratio.
- R2: A frame is a start bit 0, then `5+len` data bits with the least significant bit first, where `len` is `mode_len_i` (0..3). The line is 1 whenever `busy_o` is 0. The start bit appears in the cycle after the accepting edge.
- R3: With `mode_par_en_i`=1, one parity bit follows the data. `mode_par_even_i`=1 gives even parity: the data bits plus the parity bit hold an even number of ones. `mode_par_even_i`=0 gives odd parity.
- R4: With parity disabled, `mode_par_even_i` has no effect on the frame.
- R5: Stop code 1 sends one stop bit and stop code 3 sends two stop bits. Each bit lasts 16 ticks in 16x mode (`mode_x16_i`=1) and 1 tick in 1x mode.
- R6: Stop code 2 in 16x mode gives a stop period of 24 ticks, and `illegal_o` stays 0.
- R7: Stop code 2 in 1x mode drives `illegal_o` to 1 and sends two stop bits.
- R8: Stop code 0 holds `ready_o` at 0, `busy_o` at 0 and `txd_o` at 1, whatever `valid_i` does.
- R9: `ready_o` is 0 while `busy_o` is 1. It returns to 1 in the cycle after the tick that ends the last stop bit, and a waiting character is accepted on the next edge.
- R10: A mode write while a frame is in progress does not alter that frame.
- R11: The line and the frame position advance only on cycles with `tick_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-rate enable pulse |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_stop_i | input | 2 | Stop code: 0 sync (idle), 1 one, 2 one and a half, 3 two |
| mode_par_en_i | input | 1 | Parity enable |
| mode_par_even_i | input | 1 | Parity sense, 1 = even |
| mode_len_i | input | 2 | Data bits minus five |
| mode_x16_i | input | 1 | 1 = 16 ticks per bit, 0 = 1 tick per bit |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be taken |
| txd_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |
| illegal_o | output | 1 | One and a half stop bits requested at 1x |

## Verification
Two events can fall in the same cycle: the tick that ends the last stop bit, and a waiting character that is ready to start the next frame. The bench keeps `valid_i` high with a second character through the whole first frame. It checks that `ready_o` stays 0 up to the final tick and turns 1 exactly one cycle later. It then checks that the next start bit and first data bit follow with no extra idle cycle. A mode write is also made in the first cycle of a frame, and the bench checks that the frame on the line still follows the mode that was captured with the character.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    STOP_SYNC    = 2'd0,
    STOP_ONE     = 2'd1,
    STOP_ONEHALF = 2'd2,
    STOP_TWO     = 2'd3
  } stop_e;

  typedef struct packed {
    stop_e      stop;
    logic       par_en;
    logic       par_even;
    logic [1:0] len;
    logic       x16;
  } mode_t;

  localparam mode_t MODE_RST = '{stop: STOP_ONE, par_en: 1'b0, par_even: 1'b0,
                                 len: 2'b11, x16: 1'b1};
endpackage

// File: rtl/tx_mode_reg.sv
module tx_mode_reg
  import tx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  mode_t mode_i,
  output mode_t mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= MODE_RST;
    else if (we_i) mode_o <= mode_i;
  end
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import tx_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int FRAME_W  = 12,
  parameter int BITS_W   = 4
) (
  input  mode_t               mode_i,
  input  logic [MAX_DATA-1:0] data_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [BITS_W-1:0]   nbits_o,
  output logic                half_last_o
);
  int   nd, nstop;
  logic par;

  always_comb begin
    nd  = 5 + int'(mode_i.len);
    par = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < nd) par = par ^ data_i[i];
    if (!mode_i.par_even) par = ~par;

    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < nd) frame_o[1+i] = data_i[i];
    for (int j = 0; j < FRAME_W; j++)
      if (mode_i.par_en && j == 1 + nd) frame_o[j] = par;

    // 1.5 stop: two stop slots, last one half length; illegal at 1x -> plain two
    nstop       = (mode_i.stop == STOP_ONE) ? 1 : 2;
    nbits_o     = BITS_W'(1 + nd + int'(mode_i.par_en) + nstop);
    half_last_o = (mode_i.stop == STOP_ONEHALF) && mode_i.x16;
  end
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int FRAME_W    = 12,
  parameter int BITS_W     = 4,
  parameter int OVERSAMPLE = 16,
  parameter int CNT_W      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BITS_W-1:0]  nbits_i,
  input  logic               half_last_i,
  input  logic               x16_i,
  output logic               txd_o,
  output logic               busy_o
);
  localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [BITS_W-1:0] ONE     = BITS_W'(1);

  logic               active_q, half_q, x16_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  left_q;
  logic [CNT_W-1:0]   sub_q, lim;

  always_comb begin
    if (!x16_q)                         lim = '0;
    else if (left_q == ONE && half_q)   lim = HALF_LIM;
    else                                lim = FULL_LIM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      left_q   <= '0;
      sub_q    <= '0;
      half_q   <= 1'b0;
      x16_q    <= 1'b0;
    end else if (load_i) begin
      active_q <= 1'b1;
      sh_q     <= frame_i;
      left_q   <= nbits_i;
      sub_q    <= '0;
      half_q   <= half_last_i;
      x16_q    <= x16_i;
    end else if (active_q && tick_i) begin
      if (sub_q == lim) begin
        sub_q <= '0;
        if (left_q == ONE) begin
          active_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - ONE;
        end
      end else begin
        sub_q <= sub_q + CNT_W'(1);
      end
    end
  end

  assign txd_o  = active_q ? sh_q[0] : 1'b1;
  assign busy_o = active_q;
endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import tx_pkg::*;
#(
  parameter int MAX_DATA   = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                mode_we_i,
  input  logic [1:0]          mode_stop_i,
  input  logic                mode_par_en_i,
  input  logic                mode_par_even_i,
  input  logic [1:0]          mode_len_i,
  input  logic                mode_x16_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic                txd_o,
  output logic                busy_o,
  output logic                illegal_o
);
  localparam int FRAME_W = 1 + MAX_DATA + 1 + 2;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(OVERSAMPLE);

  mode_t              mode_d, mode_q;
  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits;
  logic               half_last, load;

  assign mode_d = '{stop: stop_e'(mode_stop_i), par_en: mode_par_en_i,
                    par_even: mode_par_even_i, len: mode_len_i, x16: mode_x16_i};

  tx_mode_reg u_mode (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(mode_we_i),
    .mode_i(mode_d), .mode_o(mode_q)
  );

  tx_frame_build #(.MAX_DATA(MAX_DATA), .FRAME_W(FRAME_W), .BITS_W(BITS_W)) u_build (
    .mode_i(mode_q), .data_i(data_i), .frame_o(frame),
    .nbits_o(nbits), .half_last_o(half_last)
  );

  tx_serializer #(.FRAME_W(FRAME_W), .BITS_W(BITS_W), .OVERSAMPLE(OVERSAMPLE),
                  .CNT_W(CNT_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .load_i(load),
    .frame_i(frame), .nbits_i(nbits), .half_last_i(half_last),
    .x16_i(mode_q.x16), .txd_o(txd_o), .busy_o(busy_o)
  );

  assign ready_o   = !busy_o && (mode_q.stop != STOP_SYNC);
  assign load      = valid_i && ready_o;
  assign illegal_o = (mode_q.stop == STOP_ONEHALF) && !mode_q.x16;
endmodule

// File: rtl/tx_char_checker.sv
module tx_char_checker
  import tx_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  tick_i,
  input logic  txd_o,
  input logic  busy_o,
  input logic  ready_o,
  input logic  illegal_o,
  input mode_t mode_q
);
  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  a_r9_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);
  a_r8_sync_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.stop == STOP_SYNC && !busy_o) |-> (!ready_o && txd_o));
  a_r7_illegal_combo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (mode_q.stop == STOP_ONEHALF && !mode_q.x16));
  a_r11_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(txd_o) && busy_o));
endmodule

bind async_char_tx tx_char_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .txd_o(txd_o),
  .busy_o(busy_o), .ready_o(ready_o), .illegal_o(illegal_o), .mode_q(mode_q)
);

// File: tb/async_char_tx_tb.sv
module async_char_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 0, rst_ni = 0, tick_i = 1, mode_we_i = 0;
  logic [1:0] mode_stop_i = 1, mode_len_i = 3;
  logic mode_par_en_i = 0, mode_par_even_i = 0, mode_x16_i = 1;
  logic [7:0] data_i = 0;
  logic valid_i = 0;
  logic ready_o, txd_o, busy_o, illegal_o;

  int n_chk = 0, n_err = 0;
  // bench copy of programmed mode
  int b_stop = 1, b_len = 3, b_x16 = 1, b_pen = 0, b_pev = 0;
  int exp_bit[16], exp_len[16], n_seg;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  async_char_tx u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_mode(int stop, int len, int x16, int pen, int pev);
    @(negedge clk_i);
    mode_stop_i = 2'(stop); mode_len_i = 2'(len); mode_x16_i = 1'(x16);
    mode_par_en_i = 1'(pen); mode_par_even_i = 1'(pev); mode_we_i = 1;
    @(negedge clk_i);
    mode_we_i = 0;
    b_stop = stop; b_len = len; b_x16 = x16; b_pen = pen; b_pev = pev;
  endtask

  task automatic build_exp(logic [7:0] d);
    int L = b_x16 ? 16 : 1;
    int nd = 5 + b_len;
    int ones = 0;
    n_seg = 0;
    exp_bit[n_seg] = 0; exp_len[n_seg] = L; n_seg++;
    for (int i = 0; i < nd; i++) begin
      exp_bit[n_seg] = int'(d[i]); exp_len[n_seg] = L; n_seg++;
      ones += int'(d[i]);
    end
    if (b_pen != 0) begin
      exp_bit[n_seg] = b_pev != 0 ? (ones % 2) : 1 - (ones % 2);
      exp_len[n_seg] = L; n_seg++;
    end
    if (b_stop == 1) begin
      exp_bit[n_seg] = 1; exp_len[n_seg] = L; n_seg++;
    end else if (b_stop == 2 && b_x16 != 0) begin
      exp_bit[n_seg] = 1; exp_len[n_seg] = 24; n_seg++;
    end else begin
      exp_bit[n_seg] = 1; exp_len[n_seg] = 2 * L; n_seg++;
    end
  endtask

  // offer a character, leave at the negedge after the accepting edge
  task automatic offer(logic [7:0] d);
    @(negedge clk_i);
    data_i = d; valid_i = 1;
    while (!ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 0;
  endtask

  task automatic send_check(string req, logic [7:0] d, bit disturb);
    int cur = 0, start = 0, total = 0;
    build_exp(d);
    for (int s = 0; s < n_seg; s++) total += exp_len[s];
    offer(d);
    if (disturb) begin
      mode_stop_i = 2'd3; mode_len_i = 2'd0; mode_par_en_i = 1;
      mode_par_even_i = 1; mode_x16_i = ~mode_x16_i; mode_we_i = 1;
    end
    for (int s = 0; s < n_seg; s++) begin
      int t = start + (exp_len[s] > 1 ? exp_len[s] / 2 : 0);
      while (cur < t) begin @(negedge clk_i); cur++; mode_we_i = 0; end
      chk({req, " bit"}, int'(txd_o), exp_bit[s]);
      start += exp_len[s];
    end
    while (cur < total - 1) begin @(negedge clk_i); cur++; mode_we_i = 0; end
    chk({req, " busy last"}, int'(busy_o), 1);
    @(negedge clk_i);
    mode_we_i = 0;
    chk({req, " busy end"}, int'(busy_o), 0);
    chk({req, " idle line"}, int'(txd_o), 1);
  endtask

  task automatic t_reset();
    chk("R1 txd", int'(txd_o), 1);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 ready", int'(ready_o), 1);
    chk("R1 illegal", int'(illegal_o), 0);
    send_check("R1 default 8N1 16x", 8'hA5, 0);
  endtask

  task automatic t_lengths();
    write_mode(1, 0, 0, 0, 0); send_check("R2 len5", 8'hF3, 0);
    write_mode(1, 1, 0, 0, 0); send_check("R2 len6", 8'h2D, 0);
    write_mode(1, 2, 0, 0, 0); send_check("R2 len7", 8'hC6, 0);
    write_mode(1, 3, 1, 0, 0); send_check("R2 len8 16x", 8'h81, 0);
  endtask

  task automatic t_parity();
    write_mode(1, 2, 0, 1, 1); send_check("R3 even", 8'h13, 0);
    write_mode(1, 2, 0, 1, 0); send_check("R3 odd", 8'h13, 0);
    write_mode(1, 3, 1, 1, 1); send_check("R3 even 16x", 8'hFF, 0);
    write_mode(1, 0, 0, 1, 0); send_check("R3 odd len5", 8'hE0, 0);
  endtask

  task automatic t_parity_off();
    write_mode(1, 3, 0, 0, 1); send_check("R4 sense1 no parity", 8'h6B, 0);
    write_mode(1, 3, 0, 0, 0); send_check("R4 sense0 no parity", 8'h6B, 0);
  endtask

  task automatic t_stops();
    write_mode(3, 3, 1, 0, 0); send_check("R5 two stop 16x", 8'h3C, 0);
    write_mode(3, 1, 0, 1, 1); send_check("R5 two stop 1x", 8'h15, 0);
    write_mode(1, 3, 0, 0, 0); send_check("R5 one stop 1x", 8'h55, 0);
  endtask

  task automatic t_half();
    write_mode(2, 3, 1, 0, 0);
    chk("R6 illegal low at 16x", int'(illegal_o), 0);
    send_check("R6 1.5 stop 16x", 8'h9A, 0);
  endtask

  task automatic t_illegal();
    write_mode(2, 3, 0, 0, 0);
    chk("R7 illegal flag", int'(illegal_o), 1);
    send_check("R7 fallback two stop", 8'h4E, 0);
    write_mode(1, 3, 0, 0, 0);
    chk("R7 illegal clears", int'(illegal_o), 0);
  endtask

  task automatic t_sync();
    int bad = 0;
    write_mode(0, 3, 0, 0, 0);
    @(negedge clk_i);
    data_i = 8'h00; valid_i = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (ready_o || busy_o || !txd_o) bad++;
    end
    valid_i = 0;
    chk("R8 sync code holds idle", bad, 0);
    write_mode(1, 3, 0, 0, 0);
    chk("R8 ready after leaving sync", int'(ready_o), 1);
  endtask

  task automatic t_backpressure();
    int early = 0;
    write_mode(1, 3, 0, 0, 0); // 10 cycles per frame
    offer(8'h01);
    data_i = 8'hFE; valid_i = 1;
    for (int i = 0; i < 9; i++) begin
      if (ready_o) early++;
      @(negedge clk_i);
    end
    chk("R9 ready low while busy", early, 0);
    chk("R9 ready at offset 9 (last stop)", int'(ready_o), 0);
    @(negedge clk_i);
    chk("R9 ready back after last stop", int'(ready_o), 1);
    chk("R9 busy low at handoff", int'(busy_o), 0);
    @(negedge clk_i);
    valid_i = 0;
    chk("R9 next start bit", int'(txd_o), 0);
    @(negedge clk_i);
    chk("R9 next first data bit", int'(txd_o), 0);
    repeat (12) @(negedge clk_i);
    chk("R9 second frame done", int'(busy_o), 0);
  endtask

  task automatic t_cfg_change();
    write_mode(1, 3, 0, 0, 0);
    send_check("R10 write during frame 1x", 8'hB7, 1);
    write_mode(1, 2, 1, 1, 0);
    send_check("R10 write during frame 16x", 8'h5A, 1);
    write_mode(1, 3, 0, 0, 0);
  endtask

  task automatic t_tick();
    int moved = 0;
    write_mode(1, 3, 0, 0, 0);
    @(negedge clk_i);
    tick_i = 0;
    offer(8'h01);
    for (int i = 0; i < 20; i++) begin
      if (txd_o || !busy_o) moved++;
      @(negedge clk_i);
    end
    chk("R11 held without tick", moved, 0);
    tick_i = 1;
    @(negedge clk_i);
    chk("R11 advance on tick", int'(txd_o), 1);
    repeat (10) @(negedge clk_i);
    chk("R11 frame completes", int'(busy_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_lengths();
    t_parity();
    t_parity_off();
    t_stops();
    t_half();
    t_illegal();
    t_sync();
    t_backpressure();
    t_cfg_change();
    t_tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule